// File: doc/BRIEF.md
# BCD Calendar Counter with 12/24-Hour Mode

This block keeps wall-clock time and date in packed BCD. A base pulse feeds a divider. Every `TICKS_PER_SEC`-th base pulse becomes one second. That second ripples through seconds, minutes, hours, day of month, month and a two-digit year. A weekday counter advances with each new day. A century flag in the top bit of the month byte flips whenever the year wraps.

A mode input selects the hour encoding. In 24-hour form the hour counts 00 to 23. In 12-hour form the hour byte carries a PM flag and counts 12, 01, …, 11, so midnight reads 12 AM and noon reads 12 PM. A parallel load writes every field in one clock. The load also restarts the divider, so the first second after a load is a whole second long.

Top module: `bcd_calendar_core`

## Requirements
- R1: Seconds and minutes count in packed BCD from 00 to 59. A counter that passes 59 goes back to 00 and advances the next field.
- R2: With `mode_24h`=1 the hour counts BCD 00 to 23 with bit 5 clear. Going from 23 to 00 advances the day.
- R3: With `mode_24h`=0, hour bit 5 is PM and bits 4:0 hold BCD 12, 01 to 11. 11 AM goes to 12 PM (0x32) with no day carry. 11 PM (0x31) goes to 12 AM (0x12) and advances the day.
- R4: The weekday counts 0 to 6 and wraps to 0. It advances only when the day advances.
- R5: Month bits 4:0 hold BCD 01 to 12. The day wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February.
- R6: February wraps after 29 when the two-digit year is divisible by four (00 included), and after 28 otherwise.
- R7: December wraps to 01 and advances the BCD year, which counts 00 to 99.
- R8: Month bit 7 is the century flag. It toggles exactly when the year wraps from 99 to 00 and holds at all other times.
- R9: The second fields advance once per `TICKS_PER_SEC` base pulses.
- R10: A load sets every field on the next clock edge and wins over a coinciding second. It clears the divider, so the next second follows `TICKS_PER_SEC` further base pulses.
- R11: Reset gives 00:00:00, weekday 0, day 01, month 01 with the century flag clear, and year 00.
- R12: Month bits 6:5 keep the value last loaded. No field changes in a cycle that has neither a second nor a load. Changing `mode_24h` alone leaves the stored hour as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-cycle base pulse, divided to seconds |
| mode_24h | input | 1 | 1: 24-hour hour encoding, 0: 12-hour with PM flag |
| load_en | input | 1 | Parallel load strobe |
| load_sec | input | 7 | BCD seconds to load |
| load_min | input | 7 | BCD minutes to load |
| load_hour | input | 6 | Hour byte to load, in the current mode's encoding |
| load_wday | input | 3 | Weekday to load |
| load_day | input | 6 | BCD day to load |
| load_month | input | 8 | Month byte to load, century flag in bit 7 |
| load_year | input | 8 | BCD year to load |
| sec_o | output | 7 | BCD seconds |
| min_o | output | 7 | BCD minutes |
| hour_o | output | 6 | Hour byte |
| wday_o | output | 3 | Weekday |
| day_o | output | 6 | BCD day of month |
| month_o | output | 8 | Month byte with century flag |
| year_o | output | 8 | BCD year |

## Verification
The bench loads every hour and minute pair at second 58 in 24-hour mode and steps two seconds. This separates the in-digit increment, the 59-to-00 wrap and the carries into the hour and the day. All 24 hours are also stepped at 59:59 in 12-hour mode, which checks the AM/PM transitions and shows that only 11 PM carries into the day. Every month of all hundred years is loaded on its last day at 23:59:59. February is also loaded on day 28. Together these cover the 30/31-day months, the leap rule, the December year carry and the century toggle. Divider checks count base pulses after a load, including a load that lands on a second.

// File: rtl/cal_pkg.sv
package cal_pkg;

  // Packed-BCD increment of a two-digit byte.
  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Leap test on a BCD year: 10*T+U mod 4 equals (2*T+U) mod 4.
  function automatic logic bcd_year_leap(input logic [7:0] yr);
    logic [4:0] s;
    s = {1'b0, yr[6:4], 1'b0} + {1'b0, yr[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  // Last BCD day of a BCD month.
  function automatic logic [5:0] last_day(input logic [4:0] mon, input logic [7:0] yr);
    logic [5:0] d;
    case (mon)
      5'h02:                      d = bcd_year_leap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: d = 6'h30;
      default:                    d = 6'h31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic base_tick,
  input  logic clear,
  output logic sec_strobe
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)          cnt_d = '0;
    else if (base_tick) cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end

  assign sec_strobe = base_tick && !clear && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cal_wrap_counter.sv
module cal_wrap_counter #(
  parameter int W = 7,
  parameter logic [7:0] MAXV = 8'h59,
  parameter logic [7:0] MINV = 8'h00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         carry
);
  import cal_pkg::*;

  localparam logic [W-1:0] TOP = W'(MAXV);
  localparam logic [W-1:0] BOT = W'(MINV);

  logic [W-1:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (load)     val_d = load_val;
    else if (inc) val_d = (val_q == TOP) ? BOT : W'(bcd_inc8(8'(val_q)));
  end

  assign carry = inc && !load && (val_q == TOP);
  assign value = val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= BOT;
    else        val_q <= val_d;
  end
endmodule

// File: rtl/cal_hour_counter.sv
module cal_hour_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_24h,
  input  logic       load,
  input  logic [5:0] load_val,
  input  logic       inc,
  output logic [5:0] value,
  output logic       carry
);
  import cal_pkg::*;

  logic [5:0] hr_q, hr_d, step24, step12;
  logic       pm;
  logic [4:0] h12;

  assign pm  = hr_q[5];
  assign h12 = hr_q[4:0];

  always_comb begin
    step24 = (hr_q == 6'h23) ? 6'h00 : 6'(bcd_inc8({2'b00, hr_q}));
    if (h12 == 5'h11)      step12 = {~pm, 5'h12};
    else if (h12 == 5'h12) step12 = {pm, 5'h01};
    else                   step12 = {pm, 5'(bcd_inc8({3'b000, h12}))};
  end

  always_comb begin
    hr_d = hr_q;
    if (load)     hr_d = load_val;
    else if (inc) hr_d = mode_24h ? step24 : step12;
  end

  assign carry = inc && !load && (mode_24h ? (hr_q == 6'h23) : (hr_q == 6'h31));
  assign value = hr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hr_q <= 6'h00;
    else        hr_q <= hr_d;
  end
endmodule

// File: rtl/cal_date_counter.sv
module cal_date_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [5:0] load_day,
  input  logic [7:0] load_month,
  input  logic       inc,
  input  logic [7:0] year,
  input  logic       century_flip,
  output logic [5:0] day,
  output logic [7:0] month,
  output logic       year_inc
);
  import cal_pkg::*;

  logic [5:0] day_q, day_d;
  logic [7:0] mon_q, mon_d;
  logic       month_end;

  assign month_end = (day_q == last_day(mon_q[4:0], year));

  always_comb begin
    day_d = day_q;
    mon_d = mon_q;
    if (load) begin
      day_d = load_day;
      mon_d = load_month;
    end else begin
      if (inc) begin
        day_d = month_end ? 6'h01 : 6'(bcd_inc8({2'b00, day_q}));
        if (month_end)
          mon_d[4:0] = (mon_q[4:0] == 5'h12) ? 5'h01 : 5'(bcd_inc8({3'b000, mon_q[4:0]}));
      end
      if (century_flip) mon_d[7] = ~mon_q[7];
    end
  end

  assign year_inc = inc && !load && month_end && (mon_q[4:0] == 5'h12);
  assign day      = day_q;
  assign month    = mon_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      day_q <= 6'h01;
      mon_q <= 8'h01;
    end else begin
      day_q <= day_d;
      mon_q <= mon_d;
    end
  end
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_tick,
  input  logic       mode_24h,
  input  logic       load_en,
  input  logic [6:0] load_sec,
  input  logic [6:0] load_min,
  input  logic [5:0] load_hour,
  input  logic [2:0] load_wday,
  input  logic [5:0] load_day,
  input  logic [7:0] load_month,
  input  logic [7:0] load_year,
  output logic [6:0] sec_o,
  output logic [6:0] min_o,
  output logic [5:0] hour_o,
  output logic [2:0] wday_o,
  output logic [5:0] day_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);
  localparam int NSIX = 2;  // seconds, minutes

  logic            sec_strobe;
  logic [NSIX:0]   chain;
  logic [6:0]      six_val [NSIX];
  logic [6:0]      six_ld  [NSIX];
  logic            day_inc, year_inc, year_wrap, wday_carry;

  cal_prescaler #(.DIV(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
    .clear(load_en), .sec_strobe(sec_strobe)
  );

  assign six_ld[0] = load_sec;
  assign six_ld[1] = load_min;
  assign chain[0]  = sec_strobe;

  generate
    for (genvar i = 0; i < NSIX; i++) begin : g_sixty
      cal_wrap_counter #(.W(7), .MAXV(8'h59), .MINV(8'h00)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load_en), .load_val(six_ld[i]),
        .inc(chain[i]), .value(six_val[i]), .carry(chain[i+1])
      );
    end
  endgenerate

  cal_hour_counter u_hour (
    .clk(clk), .rst_n(rst_n), .mode_24h(mode_24h), .load(load_en),
    .load_val(load_hour), .inc(chain[NSIX]), .value(hour_o), .carry(day_inc)
  );

  cal_wrap_counter #(.W(3), .MAXV(8'h06), .MINV(8'h00)) u_wday (
    .clk(clk), .rst_n(rst_n), .load(load_en), .load_val(load_wday),
    .inc(day_inc), .value(wday_o), .carry(wday_carry)
  );

  cal_wrap_counter #(.W(8), .MAXV(8'h99), .MINV(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n), .load(load_en), .load_val(load_year),
    .inc(year_inc), .value(year_o), .carry(year_wrap)
  );

  cal_date_counter u_date (
    .clk(clk), .rst_n(rst_n), .load(load_en), .load_day(load_day),
    .load_month(load_month), .inc(day_inc), .year(year_o),
    .century_flip(year_wrap), .day(day_o), .month(month_o), .year_inc(year_inc)
  );

  assign sec_o = six_val[0];
  assign min_o = six_val[1];

  // The weekday wrap is not used by any other field.
  logic unused_ok;
  assign unused_ok = wday_carry;
endmodule

// File: rtl/cal_core_checker.sv
module cal_core_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       load_en,
  input logic       sec_strobe,
  input logic [6:0] load_sec,
  input logic [7:0] load_year,
  input logic [6:0] sec_o,
  input logic [6:0] min_o,
  input logic [5:0] hour_o,
  input logic [2:0] wday_o,
  input logic [5:0] day_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o
);
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_strobe && !load_en && sec_o == 7'h59) |=> (sec_o == 7'h00)); // R1

  AST_SEC_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_strobe && !load_en && sec_o != 7'h59) |=> (sec_o != $past(sec_o))); // R9

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (sec_o == $past(load_sec) && year_o == $past(load_year))); // R10

  AST_LOAD_CLEARS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !sec_strobe); // R10

  AST_CENTURY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !(sec_strobe && year_o == 8'h99 && month_o[4:0] == 5'h12))
      |=> $stable(month_o[7])); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !sec_strobe) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
      && $stable(wday_o) && $stable(day_o) && $stable(month_o) && $stable(year_o))); // R12
endmodule

bind bcd_calendar_core cal_core_checker u_chk (
  .clk(clk), .rst_n(rst_n), .load_en(load_en), .sec_strobe(sec_strobe),
  .load_sec(load_sec), .load_year(load_year), .sec_o(sec_o), .min_o(min_o),
  .hour_o(hour_o), .wday_o(wday_o), .day_o(day_o), .month_o(month_o), .year_o(year_o)
);

// File: tb/bcd_calendar_core_test.sv
module bcd_calendar_core_test;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_tick = 1'b0, mode_24h = 1'b1, load_en = 1'b0;
  logic [6:0] load_sec = '0, load_min = '0;
  logic [5:0] load_hour = '0, load_day = '0;
  logic [2:0] load_wday = '0;
  logic [7:0] load_month = '0, load_year = '0;
  logic [6:0] sec_o, min_o;
  logic [5:0] hour_o, day_o;
  logic [2:0] wday_o;
  logic [7:0] month_o, year_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bcd_calendar_core #(.TICKS_PER_SEC(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .mode_24h(mode_24h),
    .load_en(load_en), .load_sec(load_sec), .load_min(load_min), .load_hour(load_hour),
    .load_wday(load_wday), .load_day(load_day), .load_month(load_month),
    .load_year(load_year), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .wday_o(wday_o), .day_o(day_o), .month_o(month_o), .year_o(year_o)
  );

  function automatic int bcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int hr12(input int h);
    return bcd((h + 11) % 12 + 1) | ((h >= 12) ? 32'h20 : 0);
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_all(input int s, input int mi, input int h, input int w,
                          input int d, input int mo, input int y);
    @(negedge clk);
    load_en = 1'b1;
    load_sec = 7'(s); load_min = 7'(mi); load_hour = 6'(h); load_wday = 3'(w);
    load_day = 6'(d); load_month = 8'(mo); load_year = 8'(y);
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      base_tick = 1'b1;
      @(negedge clk);
    end
    base_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 sec", sec_o, 0);    chk("R11 min", min_o, 0);
    chk("R11 hour", hour_o, 0);  chk("R11 wday", wday_o, 0);
    chk("R11 day", day_o, 1);    chk("R11 month", month_o, 1);
    chk("R11 year", year_o, 0);

    // R9 / R10: divider behaviour around loads
    load_all(8'h10, 8'h20, 8'h05, 2, 8'h07, 8'h03, 8'h24);
    pulses(1);
    chk("R10 no second after one pulse", sec_o, 8'h10);
    pulses(1);
    chk("R9 second after DIV pulses", sec_o, 8'h11);
    pulses(1);
    // load coinciding with the pulse that would complete a second
    @(negedge clk);
    load_en = 1'b1; base_tick = 1'b1; load_sec = 7'h40;
    @(negedge clk);
    load_en = 1'b0; base_tick = 1'b0;
    chk("R10 load wins over second", sec_o, 8'h40);
    pulses(1);
    chk("R10 divider cleared by load", sec_o, 8'h40);
    pulses(1);
    chk("R10 second after reload", sec_o, 8'h41);

    // R12: idle cycles and mode change hold every field
    repeat (5) @(negedge clk);
    mode_24h = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 hold sec", sec_o, 8'h41);
    chk("R12 hold hour", hour_o, 8'h05);
    chk("R12 hold day", day_o, 8'h07);
    mode_24h = 1'b1;
    load_all(0, 0, 0, 0, 8'h01, 8'h61, 8'h00);
    pulses(DIV);
    chk("R12 spare month bits held", month_o, 8'h61);

    // R1 R2 R4: every hour:minute in 24-hour mode
    for (int h = 0; h < 24; h++) begin
      for (int m = 0; m < 60; m++) begin
        load_all(8'h58, bcd(m), bcd(h), 3, 8'h10, 8'h05, 8'h21);
        pulses(DIV);
        chk("R1 sec to 59", sec_o, 8'h59);
        chk("R1 min held", min_o, bcd(m));
        pulses(DIV);
        chk("R1 sec wrap", sec_o, 0);
        chk("R1 min step", min_o, bcd((m + 1) % 60));
        chk("R2 hour", hour_o, (m == 59) ? bcd((h + 1) % 24) : bcd(h));
        chk("R2 day carry", day_o, (h == 23 && m == 59) ? 8'h11 : 8'h10);
        chk("R4 wday", wday_o, (h == 23 && m == 59) ? 4 : 3);
      end
    end

    // R3: 12-hour encoding over the full day
    mode_24h = 1'b0;
    for (int h = 0; h < 24; h++) begin
      load_all(8'h59, 8'h59, hr12(h), 6, 8'h10, 8'h05, 8'h21);
      pulses(DIV);
      chk("R3 hour12", hour_o, hr12((h + 1) % 24));
      chk("R3 day carry only at 11PM", day_o, (h == 23) ? 8'h11 : 8'h10);
      chk("R4 wday wrap", wday_o, (h == 23) ? 0 : 6);
    end
    mode_24h = 1'b1;

    // R5 R6 R7 R8: last day of every month for every year
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        automatic int cen = y % 2;
        automatic int w = (m + y) % 7;
        load_all(8'h59, 8'h59, 8'h23, w, bcd(mdays(m, y)), (cen << 7) | bcd(m), bcd(y));
        pulses(DIV);
        chk("R5 day wraps to 01", day_o, 1);
        chk("R7 month", month_o[4:0], bcd((m % 12) + 1));
        chk("R7 year", year_o, (m == 12) ? bcd((y + 1) % 100) : bcd(y));
        chk("R8 century", month_o[7], (m == 12 && y == 99) ? 1 - cen : cen);
        chk("R4 wday", wday_o, (w + 1) % 7);
        if (m == 2) begin
          load_all(8'h59, 8'h59, 8'h23, 0, 8'h28, 8'h02, bcd(y));
          pulses(DIV);
          chk("R6 feb 28 next", day_o, (y % 4 == 0) ? 8'h29 : 8'h01);
          chk("R6 feb month", month_o, (y % 4 == 0) ? 8'h02 : 8'h03);
        end
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule